// File: doc/BRIEF.md
# GPIO Port Bank With Change Interrupt

This block holds the register state of a bank of general-purpose pins, organised as two ports of `PORT_W` bits each. For every port it keeps an output value, a direction mask and a polarity mask, and it samples the pin levels through a two-stage synchroniser. A bus front end outside this block turns serial or parallel accesses into single-cycle write strobes and read requests. Each read returns one byte on `rdData`, one cycle after the request, together with `rdValid`.

A change detector compares every input-direction pin against the value captured by the most recent read of that port's input register. Any mismatch sets that port's pending flag. The OR of the flags drives `irqPullLow`, which enables an external open-drain pull-down and so forms an active-low interrupt line. A pending flag clears when the pin returns to the captured level, or when software reads that port's input register. Each port clears on its own.

Top module: `gpio_bank`

## Requirements
- R1: After reset the output registers hold all ones, the polarity registers all zeros and the direction registers all ones. As a result `pinOe` is all zeros, `pinOut` is all ones and `irqPullLow` is 0.
- R2: A register address is three bits. Bit 0 selects the port (0 = pins 0..7, 1 = pins 8..15). Bits [2:1] select the kind: 0 input, 1 output, 2 polarity, 3 direction. A write strobe updates the addressed register on that clock edge. A read of an output, polarity or direction register returns its stored contents unchanged.
- R3: A direction bit of 1 makes the pin an input (`pinOe` bit 0). A direction bit of 0 drives the pin (`pinOe` bit 1), and the matching output register bit appears on `pinOut`.
- R4: A read of an input register returns the synchronised pin levels of that port XOR its polarity mask, whatever the direction bits are. `rdData` and `rdValid` are valid in the cycle after `rdEn`.
- R5: Writes to an input register address change no register.
- R6: A pin change on `pinIn` reaches the change detector two clock edges later, not one.
- R7: `irqPullLow` is 1 while any input-direction pin differs from its captured level. Pins set as outputs never raise it.
- R8: A pending change clears without any read once the pin returns to its captured level.
- R9: A read of a port's input register captures that port's synchronised levels and clears that port's pending change. A change pending on the other port is left in place.
- R10: Turning a pin from output to input raises `irqPullLow` on the edge of the direction write if the pin level differs from the captured value.
- R11: The synchroniser stages and captured levels reset to all ones, so the pins' idle-high level after reset raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write register address |
| wrData | input | PORT_W | Write data |
| rdEn | input | 1 | Register read request |
| rdAddr | input | 3 | Read register address |
| rdData | output | PORT_W | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| pinIn | input | 2*PORT_W | Pin levels as seen on the pads |
| pinOe | output | 2*PORT_W | Per-pin drive enable |
| pinOut | output | 2*PORT_W | Per-pin drive value |
| irqPullLow | output | 1 | Enables the open-drain interrupt pull-down |

## Verification
The bench builds the block with its default `PORT_W` of 8, so both ports are exercised across their whole width. Single pins can be flipped at the port's edge bits 0 and 7 and in the middle. Because the two ports are only 8 bits wide, the bench can reach every path that crosses ports. These include one port pending while the other is read, a polarity mask on one port only, and a direction change on one pin among driven neighbours. All of these sit within a few dozen cycles.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NPORT  = 2;
  localparam int PSEL_W = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int ADDR_W = PSEL_W + 2;

  typedef enum logic [1:0] {
    KIND_IN  = 2'd0,
    KIND_OUT = 2'd1,
    KIND_POL = 2'd2,
    KIND_DIR = 2'd3
  } regKind_e;

  typedef struct packed {
    logic [NPORT-1:0]  wrOut;
    logic [NPORT-1:0]  wrPol;
    logic [NPORT-1:0]  wrDir;
    logic [NPORT-1:0]  capIn;
    logic              rdFire;
    regKind_e          rdKind;
    logic [PSEL_W-1:0] rdPort;
  } strobes_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobes_t          stb
);
  regKind_e          wrKind;
  regKind_e          rdKind;
  logic [PSEL_W-1:0] wrPort;
  logic [PSEL_W-1:0] rdPort;

  assign wrKind = regKind_e'(wrAddr[ADDR_W-1:PSEL_W]);
  assign rdKind = regKind_e'(rdAddr[ADDR_W-1:PSEL_W]);
  assign wrPort = wrAddr[PSEL_W-1:0];
  assign rdPort = rdAddr[PSEL_W-1:0];

  always_comb begin
    stb        = '0;
    stb.rdFire = rdEn;
    stb.rdKind = rdKind;
    stb.rdPort = rdPort;
    if (wrEn) begin
      case (wrKind)
        KIND_OUT: stb.wrOut[wrPort] = 1'b1;
        KIND_POL: stb.wrPol[wrPort] = 1'b1;
        KIND_DIR: stb.wrDir[wrPort] = 1'b1;
        default:  ;
      endcase
    end
    if (rdEn && rdKind == KIND_IN) stb.capIn[rdPort] = 1'b1;
  end

  // R5
  wr_input_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr[ADDR_W-1:PSEL_W] == 2'd0) |-> ((stb.wrOut | stb.wrPol | stb.wrDir) == '0));

  // R2
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrOut, stb.wrPol, stb.wrDir}));
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobes_t                stb,
  input  logic [PORT_W-1:0]       wrData,
  input  logic [NPORT*PORT_W-1:0] pinIn,
  output logic [NPORT*PORT_W-1:0] pinOe,
  output logic [NPORT*PORT_W-1:0] pinOut,
  output logic [PORT_W-1:0]       rdData,
  output logic                    rdValid,
  output logic                    irqPullLow
);
  logic [NPORT-1:0][PORT_W-1:0] pinVec;
  logic [NPORT-1:0][PORT_W-1:0] outReg, polReg, dirReg;
  logic [NPORT-1:0][PORT_W-1:0] syncA, syncB, latchReg;
  logic [NPORT-1:0]             pending;

  assign pinVec = pinIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg   <= '1;
      polReg   <= '0;
      dirReg   <= '1;
      syncA    <= '1;
      syncB    <= '1;
      latchReg <= '1;
    end else begin
      syncA <= pinVec;
      syncB <= syncA;
      for (int p = 0; p < NPORT; p++) begin
        if (stb.wrOut[p]) outReg[p] <= wrData;
        if (stb.wrPol[p]) polReg[p] <= wrData;
        if (stb.wrDir[p]) dirReg[p] <= wrData;
        if (stb.capIn[p]) latchReg[p] <= syncB[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.rdFire;
      if (stb.rdFire) begin
        case (stb.rdKind)
          KIND_IN:  rdData <= syncB[stb.rdPort] ^ polReg[stb.rdPort];
          KIND_OUT: rdData <= outReg[stb.rdPort];
          KIND_POL: rdData <= polReg[stb.rdPort];
          default:  rdData <= dirReg[stb.rdPort];
        endcase
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++)
      pending[p] = |((syncB[p] ^ latchReg[p]) & dirReg[p]);
  end

  assign irqPullLow = |pending;
  assign pinOe      = ~dirReg;
  assign pinOut     = outReg;

  for (genvar p = 0; p < NPORT; p++) begin : gChk
    // R2
    wr_out_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb.wrOut[p] |=> (outReg[p] == $past(wrData)));
    // R9
    cap_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb.capIn[p] |=> (latchReg[p] == $past(syncB[p])));
  end

  // R7
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dirReg == '0) |-> !irqPullLow);

  // R4
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdFire |=> rdValid);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [PORT_W-1:0]       wrData,
  input  logic                    rdEn,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic [PORT_W-1:0]       rdData,
  output logic                    rdValid,
  input  logic [NPORT*PORT_W-1:0] pinIn,
  output logic [NPORT*PORT_W-1:0] pinOe,
  output logic [NPORT*PORT_W-1:0] pinOut,
  output logic                    irqPullLow
);
  strobes_t stb;

  gpio_bank_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .rdEn   (rdEn),
    .rdAddr (rdAddr),
    .stb    (stb)
  );

  gpio_bank_dp #(.PORT_W(PORT_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .pinIn      (pinIn),
    .pinOe      (pinOe),
    .pinOut     (pinOut),
    .rdData     (rdData),
    .rdValid    (rdValid),
    .irqPullLow (irqPullLow)
  );
endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        rdEn = 1'b0;
  logic [2:0]  rdAddr = '0;
  logic [7:0]  rdData;
  logic        rdValid;
  logic [15:0] pinIn = 16'hFFFF;
  logic [15:0] pinOe, pinOut;
  logic        irqPullLow;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] polM[2];

  always #4 clk = ~clk;

  gpio_bank uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid),
    .pinIn(pinIn), .pinOe(pinOe), .pinOut(pinOut), .irqPullLow(irqPullLow)
  );

  task automatic checkVal(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setPins(input logic [15:0] v);
    @(negedge clk);
    pinIn = v;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [7:0] inExp(input int p);
    return pinIn[p*8 +: 8] ^ polM[p];
  endfunction

  // Scoreboard monitor: compares each returned read against the queue
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL R4 unexpected rdValid actual=%h expected=none", rdData);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checkVal(t, {8'h00, rdData}, {8'h00, e});
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    polM[0] = 8'h00; polM[1] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state, R11 idle-high pins raise nothing
    checkVal("R1 pinOe", pinOe, 16'h0000);
    checkVal("R1 pinOut", pinOut, 16'hFFFF);
    checkVal("R11 irq after reset", {15'd0, irqPullLow}, 16'd0);
    readReg(3'd2, 8'hFF, "R1 out0");
    readReg(3'd3, 8'hFF, "R1 out1");
    readReg(3'd4, 8'h00, "R1 pol0");
    readReg(3'd7, 8'hFF, "R1 dir1");

    // R2 R3 writes and drive
    writeReg(3'd2, 8'hA5);
    writeReg(3'd6, 8'h0F);
    checkVal("R3 pinOe", pinOe, 16'h00F0);
    checkVal("R3 pinOut", pinOut, 16'hFFA5);
    readReg(3'd2, 8'hA5, "R2 out0");
    readReg(3'd6, 8'h0F, "R2 dir0");
    readReg(3'd3, 8'hFF, "R2 out1 untouched");

    // R6 two-edge synchroniser on port1 pin 15
    @(negedge clk);
    pinIn = 16'h7FFF;
    @(negedge clk);
    checkVal("R6 one edge", {15'd0, irqPullLow}, 16'd0);
    @(negedge clk);
    checkVal("R6 two edges", {15'd0, irqPullLow}, 16'd1);
    readReg(3'd1, 8'h7F, "R9 in1 capture");
    checkVal("R9 irq cleared", {15'd0, irqPullLow}, 16'd0);

    // R7 R9 both ports pending, reads clear independently; R4 polarity
    setPins(16'h3C5A);
    checkVal("R7 irq on input change", {15'd0, irqPullLow}, 16'd1);
    polM[1] = 8'hFF;
    writeReg(3'd5, 8'hFF);
    readReg(3'd0, inExp(0), "R4 in0");
    checkVal("R9 port1 still pending", {15'd0, irqPullLow}, 16'd1);
    readReg(3'd1, inExp(1), "R4 in1 inverted");
    checkVal("R9 both cleared", {15'd0, irqPullLow}, 16'd0);

    // R8 return to captured level clears
    setPins(pinIn ^ 16'h0200);
    checkVal("R8 irq set", {15'd0, irqPullLow}, 16'd1);
    setPins(pinIn ^ 16'h0200);
    checkVal("R8 irq self-clear", {15'd0, irqPullLow}, 16'd0);

    // R7 output pin (port0 bit4) change never interrupts
    setPins(pinIn ^ 16'h0010);
    checkVal("R7 output pin quiet", {15'd0, irqPullLow}, 16'd0);

    // R10 turning bit4 to input raises the interrupt at once
    writeReg(3'd6, 8'h1F);
    checkVal("R10 irq on dir change", {15'd0, irqPullLow}, 16'd1);
    readReg(3'd0, inExp(0), "R4 in0 output pins visible");
    checkVal("R9 clear after dir change", {15'd0, irqPullLow}, 16'd0);

    // R5 writes to input addresses ignored
    writeReg(3'd0, 8'h00);
    writeReg(3'd1, 8'h00);
    readReg(3'd2, 8'hA5, "R5 out0 kept");
    readReg(3'd6, 8'h1F, "R5 dir0 kept");
    readReg(3'd5, 8'hFF, "R5 pol1 kept");
    readReg(3'd1, inExp(1), "R5 in1 unchanged");
    checkVal("R5 pinOut", pinOut, 16'hFFA5);
    checkVal("R5 irq", {15'd0, irqPullLow}, 16'd0);

    // R9 port0 pending only, read of port1 leaves it set
    setPins(pinIn ^ 16'h0001);
    readReg(3'd1, inExp(1), "R9 in1 read");
    checkVal("R9 port0 kept pending", {15'd0, irqPullLow}, 16'd1);

    repeat (3) @(negedge clk);
    checkVal("R4 all reads returned", expQ.size(), 16'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule